// File: doc/BRIEF.md
# IDE Bus-Master Register Block

This block is the software-visible control point of a two-channel IDE controller that moves data by bus-master DMA. A host reaches it over a simple byte-addressed I/O port. For each channel it keeps a command byte, a status byte and a 32-bit pointer to the descriptor table. The command byte sends start, stop and direction to an external DMA engine. The engine, in turn, reports activity, errors and completion back into the status byte.

Each channel also latches the interrupt request that comes from its drive. The two latched requests are merged into one legacy interrupt output. That output is passed on only while a programmable interrupt-line number is nonzero. The line number is loaded through a separate configuration write port.

Each channel has an 8-byte slice of the window, and the channel index is the address above bit 2. In the lower half of a slice, offset 0 is the command byte and offset 2 is the status byte. The upper half holds the table pointer. Access widths are coded as 0 = byte, 1 = halfword, 2 = word, and 3 is handled like a word. Write data and read data are aligned to the addressed byte, so bits 7:0 carry the byte at the access address.

Top module: `ide_bm_regs`

## Requirements
- R1: Channel n's command byte reads at offset n*8, its status byte at n*8+2, and its table pointer at n*8+4. Reads are combinational on the current address and width.
- R2: In the command/status half of a slice, byte reads at offsets 1 and 3 return 0xFF, and byte writes there change nothing.
- R3: In the command/status half, a write that is not one byte wide is ignored. A read that is not one byte wide returns all ones for its width: 0xFFFF for a halfword, 0xFFFFFFFF for a word.
- R4: A byte write to status loads bits 6:5 from the data. It clears bit 1 and bit 2 where the data bit is 1 and keeps them where it is 0. Bit 0 is unchanged by the write, and bits 3, 4 and 7 always read 0.
- R5: Status bit 0 (active) is set by the engine's active-set input and cleared by its active-clear input. If both arrive in the same cycle, set wins.
- R6: Status bit 1 (error) and bit 2 (interrupt) are set by the engine's error and interrupt inputs. A hardware set wins over a software clear in the same cycle.
- R7: A byte write to the command byte keeps only bit 0 (start) and bit 3 (direction); other bits read 0. The direction output equals bit 3.
- R8: One cycle after a byte write moves command bit 0 from 0 to 1, the start strobe is high for exactly one cycle. A write that moves bit 0 from 1 to 0 gives a one-cycle stop strobe instead. Writes that leave bit 0 unchanged give no strobe.
- R9: Each channel's pending flag takes the value of that channel's drive request at every clock, so it follows the request with one cycle of latency.
- R10: The interrupt output is the OR of the pending flags when the line number is nonzero, and is 0 when the line number is 0.
- R11: Only bits 3:0 of the line number are writable; bits 7:4 read 0. Its reset value is 14.
- R12: The table pointer accepts writes of any width on the lanes the access covers, within its 4 bytes. Bits 1:0 always read 0.
- R13: After reset, every command, status, pointer and pending bit is 0, and no strobe or interrupt is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Byte address inside the 16-byte window |
| bus_size_i | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| bus_we_i | input | 1 | Write strobe for the current access |
| bus_wdata_i | input | 32 | Write data, aligned to the addressed byte |
| bus_rdata_o | output | 32 | Read data for the current address and width |
| line_we_i | input | 1 | Interrupt-line number write strobe |
| line_wdata_i | input | 8 | Interrupt-line write data |
| line_o | output | 8 | Current interrupt-line number |
| drv_irq_i | input | 2 | Raw interrupt request from each channel's drive |
| act_set_i | input | 2 | Engine: transfer started, per channel |
| act_clr_i | input | 2 | Engine: transfer ended, per channel |
| err_set_i | input | 2 | Engine: error event, per channel |
| int_set_i | input | 2 | Engine/drive: interrupt event, per channel |
| dma_start_o | output | 2 | One-cycle start strobe, per channel |
| dma_stop_o | output | 2 | One-cycle stop strobe, per channel |
| dma_dir_o | output | 2 | Transfer direction (1 = write to memory), per channel |
| irq_o | output | 1 | Merged legacy interrupt level |

## Verification
The status byte is the hardest part. The bench drives software writes that carry ones in bits 1 and 2 in the same cycle as engine set events. A design with the priority reversed would lose an error or completion that landed on the clear. A design that treated bit 0 as writable would let software fake a running transfer.

Width handling is the second target. The bench sends halfword and word accesses to the command/status half and to the padding offsets. A design that decoded the address but not the width would change the command byte on a wide write, or return register contents where all ones are expected. Table-pointer writes of partial width at offsets 1 to 3 check lane placement and the forced-zero low bits.

The interrupt path is run with the line number at zero and at nonzero values while drive requests toggle. This shows whether the gate is applied and whether the pending flags lag the requests by one clock.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int unsigned CMD_GO_BIT  = 0;
  localparam int unsigned CMD_DIR_BIT = 3;
  localparam logic [7:0]  CMD_MASK    = 8'h09;

  localparam int unsigned ST_ACT   = 0;
  localparam int unsigned ST_ERR   = 1;
  localparam int unsigned ST_INT   = 2;
  localparam int unsigned ST_RW_LO = 5;
  localparam int unsigned ST_RW_HI = 6;

  function automatic logic [31:0] size_ones(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00ff;
      SZ_HALF: return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic int size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        grp_we_i,
  input  logic        ptr_we_i,
  input  logic [1:0]  off_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  input  logic        drv_irq_i,
  input  logic        act_set_i,
  input  logic        act_clr_i,
  input  logic        err_set_i,
  input  logic        int_set_i,
  output logic [7:0]  cmd_o,
  output logic [7:0]  stat_o,
  output logic [31:0] ptr_o,
  output logic        start_o,
  output logic        stop_o,
  output logic        dir_o,
  output logic        pend_o
);
  logic        byte_acc, cmd_we, stat_we;
  logic [7:0]  cmd_q, stat_q, stat_d;
  logic [31:2] ptr_q;
  logic [31:0] ptr_d;
  logic        start_q, stop_q, pend_q;

  assign byte_acc = (size_i == SZ_BYTE);
  assign cmd_we   = grp_we_i && byte_acc && (off_i == 2'd0);
  assign stat_we  = grp_we_i && byte_acc && (off_i == 2'd2);

  always_comb begin
    stat_d = stat_q;
    if (stat_we) begin
      stat_d[ST_RW_HI:ST_RW_LO] = wdata_i[ST_RW_HI:ST_RW_LO];
      stat_d[ST_INT:ST_ERR]     = stat_q[ST_INT:ST_ERR] & ~wdata_i[ST_INT:ST_ERR];
    end
    // hardware events override software in the same cycle
    if (act_set_i)      stat_d[ST_ACT] = 1'b1;
    else if (act_clr_i) stat_d[ST_ACT] = 1'b0;
    if (err_set_i)      stat_d[ST_ERR] = 1'b1;
    if (int_set_i)      stat_d[ST_INT] = 1'b1;
  end

  always_comb begin
    ptr_d = {ptr_q, 2'b00};
    for (int k = 0; k < 4; k++) begin
      if (ptr_we_i && (k >= int'(off_i)) && ((k - int'(off_i)) < size_bytes(size_i)))
        ptr_d[8*k +: 8] = 8'(wdata_i >> (8 * (k - int'(off_i))));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      stat_q  <= '0;
      ptr_q   <= '0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= wdata_i[7:0] & CMD_MASK;
      stat_q  <= stat_d;
      ptr_q   <= ptr_d[31:2];
      start_q <= cmd_we &&  wdata_i[CMD_GO_BIT] && !cmd_q[CMD_GO_BIT];
      stop_q  <= cmd_we && !wdata_i[CMD_GO_BIT] &&  cmd_q[CMD_GO_BIT];
      pend_q  <= drv_irq_i;
    end
  end

  assign cmd_o   = cmd_q;
  assign stat_o  = stat_q;
  assign ptr_o   = {ptr_q, 2'b00};
  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign dir_o   = cmd_q[CMD_DIR_BIT];
  assign pend_o  = pend_q;
endmodule

// File: rtl/ide_bm_irq.sv
module ide_bm_irq #(
  parameter int NUM_CH   = 2,
  parameter int LINE_W   = 4,
  parameter int LINE_RST = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_we_i,
  input  logic [7:0]        line_wdata_i,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [7:0]        line_o,
  output logic              irq_o
);
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        line_q <= LINE_W'(LINE_RST);
    else if (line_we_i) line_q <= line_wdata_i[LINE_W-1:0];
  end

  assign line_o = 8'(line_q);
  assign irq_o  = (|pend_i) && (line_q != '0);
endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int LINE_W   = 4,
  parameter int LINE_RST = 14,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW      = CH_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [1:0]        bus_size_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              line_we_i,
  input  logic [7:0]        line_wdata_i,
  output logic [7:0]        line_o,
  input  logic [NUM_CH-1:0] drv_irq_i,
  input  logic [NUM_CH-1:0] act_set_i,
  input  logic [NUM_CH-1:0] act_clr_i,
  input  logic [NUM_CH-1:0] err_set_i,
  input  logic [NUM_CH-1:0] int_set_i,
  output logic [NUM_CH-1:0] dma_start_o,
  output logic [NUM_CH-1:0] dma_stop_o,
  output logic [NUM_CH-1:0] dma_dir_o,
  output logic              irq_o
);
  logic [CH_W-1:0]   ch;
  logic [1:0]        off;
  logic              ch_ok;
  logic [7:0]        cmd_a  [NUM_CH];
  logic [7:0]        stat_a [NUM_CH];
  logic [31:0]       ptr_a  [NUM_CH];
  logic [NUM_CH-1:0] pend;

  assign ch    = bus_addr_i[AW-1:3];
  assign off   = bus_addr_i[1:0];
  assign ch_ok = int'(ch) < NUM_CH;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic hit;
    assign hit = bus_we_i && (ch == CH_W'(n));

    ide_bm_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .grp_we_i  (hit && !bus_addr_i[2]),
      .ptr_we_i  (hit &&  bus_addr_i[2]),
      .off_i     (off),
      .size_i    (bus_size_i),
      .wdata_i   (bus_wdata_i),
      .drv_irq_i (drv_irq_i[n]),
      .act_set_i (act_set_i[n]),
      .act_clr_i (act_clr_i[n]),
      .err_set_i (err_set_i[n]),
      .int_set_i (int_set_i[n]),
      .cmd_o     (cmd_a[n]),
      .stat_o    (stat_a[n]),
      .ptr_o     (ptr_a[n]),
      .start_o   (dma_start_o[n]),
      .stop_o    (dma_stop_o[n]),
      .dir_o     (dma_dir_o[n]),
      .pend_o    (pend[n])
    );
  end

  always_comb begin
    bus_rdata_o = size_ones(bus_size_i);
    if (ch_ok) begin
      if (bus_addr_i[2]) begin
        bus_rdata_o = (ptr_a[ch] >> {off, 3'b000}) & size_ones(bus_size_i);
      end else if (bus_size_i == SZ_BYTE) begin
        case (off)
          2'd0:    bus_rdata_o = 32'(cmd_a[ch]);
          2'd2:    bus_rdata_o = 32'(stat_a[ch]);
          default: bus_rdata_o = 32'h0000_00ff;
        endcase
      end
    end
  end

  ide_bm_irq #(
    .NUM_CH   (NUM_CH),
    .LINE_W   (LINE_W),
    .LINE_RST (LINE_RST)
  ) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_we_i    (line_we_i),
    .line_wdata_i (line_wdata_i),
    .pend_i       (pend),
    .line_o       (line_o),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/ide_bm_chk.sv
module ide_bm_chk
  import ide_bm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int AW     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     bus_addr_i,
  input logic [1:0]        bus_size_i,
  input logic [31:0]       bus_rdata_o,
  input logic [7:0]        line_o,
  input logic [NUM_CH-1:0] drv_irq_i,
  input logic [NUM_CH-1:0] dma_start_o,
  input logic [NUM_CH-1:0] dma_stop_o,
  input logic              irq_o
);
  logic armed;
  logic ch_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assign ch_ok = int'(bus_addr_i[AW-1:3]) < NUM_CH;

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (line_o != 8'd0));

  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && line_o != 8'd0) |-> (irq_o == (|$past(drv_irq_i))));

  // R3
  wide_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_ok && !bus_addr_i[2] && bus_size_i != SZ_BYTE) |-> (bus_rdata_o == size_ones(bus_size_i)));

  // R2
  pad_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_ok && !bus_addr_i[2] && bus_addr_i[0] && bus_size_i == SZ_BYTE) |-> (bus_rdata_o == 32'h0000_00ff));

  // R12
  ptr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_ok && bus_addr_i[2:0] == 3'd4) |-> (bus_rdata_o[1:0] == 2'b00));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_strb
    // R8
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dma_start_o[n] && dma_stop_o[n]));
    // R8
    start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_start_o[n] |=> !dma_start_o[n]);
    // R8
    stop_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_stop_o[n] |=> !dma_stop_o[n]);
  end
endmodule

bind ide_bm_regs ide_bm_chk #(
  .NUM_CH (NUM_CH),
  .AW     (AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_size_i  (bus_size_i),
  .bus_rdata_o (bus_rdata_o),
  .line_o      (line_o),
  .drv_irq_i   (drv_irq_i),
  .dma_start_o (dma_start_o),
  .dma_stop_o  (dma_stop_o),
  .irq_o       (irq_o)
);

// File: tb/ide_bm_regs_tb.sv
module ide_bm_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  b_addr = '0;
  logic [1:0]  b_size = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_wd = '0;
  logic [31:0] b_rd;
  logic        l_we = 1'b0;
  logic [7:0]  l_wd = '0;
  logic [7:0]  l_o;
  logic [1:0]  drv = '0, aset = '0, aclr = '0, eset = '0, iset = '0;
  logic [1:0]  start_o, stop_o, dir_o;
  logic        irq_o;

  int errs = 0;
  int checks = 0;

  ide_bm_regs u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_addr_i(b_addr), .bus_size_i(b_size), .bus_we_i(b_we),
    .bus_wdata_i(b_wd), .bus_rdata_o(b_rd),
    .line_we_i(l_we), .line_wdata_i(l_wd), .line_o(l_o),
    .drv_irq_i(drv), .act_set_i(aset), .act_clr_i(aclr),
    .err_set_i(eset), .int_set_i(iset),
    .dma_start_o(start_o), .dma_stop_o(stop_o), .dma_dir_o(dir_o),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model
  logic [7:0]  m_cmd [2];
  logic [7:0]  m_st  [2];
  logic [31:0] m_ptr [2];
  logic [3:0]  m_line;
  logic [1:0]  m_pend, m_start, m_stop;

  function automatic logic [31:0] ones(input logic [1:0] s);
    return (s == 2'd0) ? 32'hff : (s == 2'd1) ? 32'hffff : 32'hffff_ffff;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] s);
    int n = int'(a[3]);
    int o = int'(a[1:0]);
    if (a[2]) return (m_ptr[n] >> (8 * o)) & ones(s);
    if (s != 2'd0) return ones(s);
    if (o == 0) return {24'd0, m_cmd[n]};
    if (o == 2) return {24'd0, m_st[n]};
    return 32'hff;
  endfunction

  task automatic model_reset();
    for (int n = 0; n < 2; n++) begin
      m_cmd[n] = '0; m_st[n] = '0; m_ptr[n] = '0;
    end
    m_line = 4'd14; m_pend = '0; m_start = '0; m_stop = '0;
  endtask

  task automatic model_update();
    for (int n = 0; n < 2; n++) begin
      logic grp, byt, wcmd, wst;
      logic [7:0] st;
      int o, nb;
      grp  = b_we && (int'(b_addr[3]) == n) && !b_addr[2];
      byt  = (b_size == 2'd0);
      o    = int'(b_addr[1:0]);
      wcmd = grp && byt && (o == 0);
      wst  = grp && byt && (o == 2);
      m_start[n] = wcmd &&  b_wd[0] && !m_cmd[n][0];
      m_stop[n]  = wcmd && !b_wd[0] &&  m_cmd[n][0];
      if (wcmd) m_cmd[n] = b_wd[7:0] & 8'h09;
      st = m_st[n];
      if (wst) begin
        st[6:5] = b_wd[6:5];
        if (b_wd[1]) st[1] = 1'b0;
        if (b_wd[2]) st[2] = 1'b0;
      end
      if (aset[n]) st[0] = 1'b1; else if (aclr[n]) st[0] = 1'b0;
      if (eset[n]) st[1] = 1'b1;
      if (iset[n]) st[2] = 1'b1;
      m_st[n] = st;
      if (b_we && (int'(b_addr[3]) == n) && b_addr[2]) begin
        nb = byt ? 1 : (b_size == 2'd1) ? 2 : 4;
        for (int k = 0; k < 4; k++)
          if (k >= o && (k - o) < nb) m_ptr[n][8*k +: 8] = b_wd[8*(k-o) +: 8];
        m_ptr[n][1:0] = 2'b00;
      end
    end
    m_pend = drv;
    if (l_we) m_line = l_wd[3:0];
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outputs();
    chk("R10 irq", 32'(irq_o), 32'((|m_pend) && (m_line != 4'd0)));
    chk("R8 start", 32'(start_o), 32'(m_start));
    chk("R8 stop", 32'(stop_o), 32'(m_stop));
    chk("R7 dir", 32'(dir_o), 32'({m_cmd[1][3], m_cmd[0][3]}));
    chk("R11 line", 32'(l_o), 32'(m_line));
  endtask

  task automatic step();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    chk_outputs();
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [1:0] s);
    b_we = 1'b0; b_addr = a; b_size = s;
    #1;
    chk(tag, b_rd, exp_read(a, s));
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    b_we = 1'b1; b_addr = a; b_size = s; b_wd = d;
    step();
    b_we = 1'b0;
  endtask

  task automatic idle();
    aset = '0; aclr = '0; eset = '0; iset = '0; l_we = 1'b0; b_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R13 reset state
    chk_outputs();
    for (int a = 0; a < 16; a += 2) rd("R13 reset read", 4'(a), 2'd0);
    rd("R13 ptr word", 4'd4, 2'd2);
    chk("R11 reset line", 32'(l_o), 32'd14);

    // R7 R8 command and strobes
    wr(4'd0, 2'd0, 32'hff);
    chk("R8 start literal", 32'(start_o), 32'd1);
    rd("R7 cmd mask", 4'd0, 2'd0);
    chk("R7 cmd literal", b_rd, 32'h09);
    wr(4'd0, 2'd0, 32'h01);
    chk("R8 no strobe on same", 32'(start_o | stop_o), 32'd0);
    wr(4'd0, 2'd0, 32'h00);
    chk("R8 stop literal", 32'(stop_o), 32'd1);
    step();

    // R3 wide writes ignored
    wr(4'd8, 2'd1, 32'h0000_ffff);
    rd("R3 cmd untouched", 4'd8, 2'd0);
    rd("R3 half read", 4'd8, 2'd1);
    rd("R3 word read", 4'd10, 2'd2);
    wr(4'd10, 2'd2, 32'hffff_ffff);
    rd("R3 status untouched", 4'd10, 2'd0);

    // R2 padding
    wr(4'd1, 2'd0, 32'hff);
    wr(4'd3, 2'd0, 32'hff);
    rd("R2 pad1", 4'd1, 2'd0);
    rd("R2 pad3", 4'd3, 2'd0);
    rd("R2 cmd after pad", 4'd0, 2'd0);
    rd("R2 st after pad", 4'd2, 2'd0);

    // R4 R5 R6 status
    eset = 2'b01; iset = 2'b01; aset = 2'b01; step(); idle();
    wr(4'd2, 2'd0, 32'hff);
    rd("R4 status w1c", 4'd2, 2'd0);
    chk("R4 status literal", b_rd, 32'h61);
    aset = 2'b01; aclr = 2'b01; eset = 2'b01;
    wr(4'd2, 2'd0, 32'h06); idle();
    rd("R6 set beats clear", 4'd2, 2'd0);
    chk("R5 R6 literal", b_rd, 32'h03);
    aclr = 2'b01; step(); idle();
    rd("R5 active clear", 4'd2, 2'd0);

    // R12 pointer lanes
    wr(4'd4, 2'd2, 32'hdead_beef);
    rd("R12 ptr word", 4'd4, 2'd2);
    chk("R12 ptr literal", b_rd, 32'hdead_beec);
    wr(4'd6, 2'd0, 32'h12);
    rd("R12 lane2", 4'd4, 2'd2);
    wr(4'd15, 2'd2, 32'h5555_5577);
    rd("R12 clipped", 4'd12, 2'd2);
    rd("R1 ptr byte off", 4'd13, 2'd1);

    // R9 R10 interrupt gating
    l_we = 1'b1; l_wd = 8'hf0; step(); idle();
    chk("R11 upper bits", 32'(l_o), 32'd0);
    drv = 2'b10; step();
    chk("R10 gated off", 32'(irq_o), 32'd0);
    l_we = 1'b1; l_wd = 8'h05; step(); idle();
    chk("R10 routed", 32'(irq_o), 32'd1);
    drv = 2'b00; #1;
    chk("R9 lag", 32'(irq_o), 32'd1);
    step();
    chk("R9 cleared", 32'(irq_o), 32'd0);

    // random traffic, all R1..R12
    for (int i = 0; i < 4000; i++) begin
      b_we   = ($urandom % 2) == 0;
      b_addr = 4'($urandom);
      b_size = (($urandom % 3) == 0) ? 2'($urandom) : 2'd0;
      b_wd   = $urandom;
      aset   = 2'($urandom & $urandom);
      aclr   = 2'($urandom & $urandom);
      eset   = 2'($urandom & $urandom & $urandom);
      iset   = 2'($urandom & $urandom & $urandom);
      if (($urandom % 4) == 0) drv = 2'($urandom);
      l_we   = ($urandom % 40) == 0;
      l_wd   = (($urandom % 3) == 0) ? 8'h00 : 8'($urandom);
      #1;
      chk("R1 random read", b_rd, exp_read(b_addr, b_size));
      step();
    end
    idle();
    for (int a = 0; a < 16; a++) rd("R1 final sweep", 4'(a), 2'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule